// File: doc/BRIEF.md
# Iterative Shift-and-Add Unsigned Multiplier

This block multiplies two unsigned 32-bit words and returns the full 64-bit product, spending one clock cycle per multiplier bit. A single adder and one double-width register do all the work: the multiplier bits are parked in the lower half of that register, and each cycle the lowest bit decides whether the stored multiplicand is added into the upper half. The whole register then moves one place to the right, consuming that multiplier bit.

A client presents both operands with a one-cycle start pulse while the block is idle. The block raises busy for exactly the number of steps equal to the operand width, then pulses done for a single cycle, at which point the high and low product words are valid. They stay valid until the next accepted start. Start pulses that arrive while busy are dropped.

Top module: `shift_add_mult`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, busy_o and done_o are 0 and hi_o and lo_o are all zeros.
- R2: A start_i pulse sampled while busy_o is 0 captures both operands, and busy_o is 1 in the following cycle.
- R3: After an accepted start, busy_o stays 1 for exactly 32 consecutive cycles, and done_o is 1 in the cycle right after busy_o falls.
- R4: When done_o is 1, {hi_o, lo_o} equals the unsigned product of the two captured operands, hi_o carrying bits 63..32 and lo_o bits 31..0.
- R5: No carry out of the upper-half addition is lost: all-ones times all-ones gives hi_o = 32'hFFFFFFFE and lo_o = 32'h00000001.
- R6: A start_i pulse while busy_o is 1 is ignored: neither the result nor the 32-cycle length of the current operation changes.
- R7: While busy_o is 0 and no start is accepted, hi_o and lo_o keep their values, whatever the operand inputs do.
- R8: done_o is high for a single cycle per operation and is never high together with busy_o.
- R9: A zero operand on either side produces an all-zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, deasserted in step with clk |
| start_i | input | 1 | Begin an operation; honoured only while not busy |
| mcand_i | input | 32 | Multiplicand operand, unsigned |
| mplier_i | input | 32 | Multiplier operand, unsigned |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse marking a valid product |
| hi_o | output | 32 | Upper half of the product |
| lo_o | output | 32 | Lower half of the product |

## Verification
On every cycle the assertions watch the control shape: busy rising after an idle start, a busy run of exactly 32 cycles measured by a counter in the checker, the done pulse following the fall of busy and lasting one cycle, and the product words standing still while idle with no start. The numerical correctness of the product, including the carry case with all-ones operands, zero operands and random operand pairs, and the fact that a start issued mid-run leaves the result untouched, can only be shown by the bench comparing finished products against values it computes itself.

// File: rtl/mul_pkg.sv
package mul_pkg;
  localparam int unsigned DEF_WIDTH = 32;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_RUN  = 2'd1,
    MS_FIN  = 2'd2
  } mul_state_e;

  function automatic int unsigned cnt_bits(input int unsigned steps);
    return (steps > 1) ? $clog2(steps) : 1;
  endfunction
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int unsigned STEPS = DEF_WIDTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int unsigned CNT_W = cnt_bits(STEPS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  mul_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    load    = 1'b0;
    unique case (state_q)
      MS_RUN: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + CNT_W'(1);
        if (cnt_q == LAST) begin
          state_d = MS_FIN;
        end
      end
      MS_FIN, MS_IDLE: begin
        if (start) begin
          load    = 1'b1;
          cnt_en  = 1'b1;
          cnt_d   = '0;
          state_d = MS_RUN;
        end else begin
          state_d = MS_IDLE;
        end
      end
      default: state_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign step = (state_q == MS_RUN);
  assign busy = (state_q == MS_RUN);
  assign done = (state_q == MS_FIN);
endmodule

// File: rtl/mul_adder.sv
module mul_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] addend,
  input  logic         use_addend,
  output logic [W:0]   sum
);
  logic [W-1:0] gated;

  assign gated = use_addend ? addend : '0;
  assign sum   = {1'b0, acc} + {1'b0, gated};
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic [2*W-1:0] prod
);
  localparam int unsigned PW = 2 * W;

  logic [W-1:0]  mcand_q;
  logic [PW-1:0] prod_q, prod_d;
  logic          prod_en;
  logic [W:0]    upper_sum;

  mul_adder #(.W(W)) u_add (
    .acc        (prod_q[PW-1:W]),
    .addend     (mcand_q),
    .use_addend (prod_q[0]),
    .sum        (upper_sum)
  );

  always_comb begin
    prod_en = load | step;
    if (load) begin
      prod_d = {{W{1'b0}}, mplier_in};
    end else begin
      prod_d = {upper_sum, prod_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
    end else if (load) begin
      mcand_q <= mcand_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
    end else if (prod_en) begin
      prod_q <= prod_d;
    end
  end

  assign prod = prod_q;
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult
  import mul_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  localparam int unsigned PW = 2 * WIDTH;

  logic          load, step;
  logic [PW-1:0] prod;

  mul_ctrl #(.STEPS(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_i),
    .load  (load),
    .step  (step),
    .busy  (busy_o),
    .done  (done_o)
  );

  mul_datapath #(.W(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .mcand_in  (mcand_i),
    .mplier_in (mplier_i),
    .prod      (prod)
  );

  assign hi_o = prod[PW-1:WIDTH];
  assign lo_o = prod[WIDTH-1:0];
endmodule

// File: rtl/shift_add_mult_chk.sv
module shift_add_mult_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] hi_o,
  input logic [WIDTH-1:0] lo_o
);
  localparam int unsigned RW = $clog2(WIDTH + 2) + 1;

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (busy_o) begin
      run_q <= run_q + RW'(1);
    end else begin
      run_q <= '0;
    end
  end

  always_comb begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (!busy_o && !done_o);
    end
  end

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_run_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_q == RW'(WIDTH)));

  assert_done_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  assert_run_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_q < RW'(WIDTH)));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(hi_o) && $stable(lo_o)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o));
endmodule

bind shift_add_mult shift_add_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .hi_o    (hi_o),
  .lo_o    (lo_o)
);

// File: tb/tb_shift_add_mult.sv
`timescale 1ns/1ps
module tb_shift_add_mult;
  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic [W-1:0] mcand_i, mplier_i;
  logic         busy_o, done_o;
  logic [W-1:0] hi_o, lo_o;

  int total = 0;
  int bad   = 0;

  shift_add_mult #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .mcand_i(mcand_i), .mplier_i(mplier_i),
    .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [63:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [63:0] acc = '0;
    for (int i = 0; i < W; i++) begin
      if (b[i]) acc = acc + ({32'b0, a} << i);
    end
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One full operation; poke=1 issues a start with other operands mid-run (R6).
  task automatic do_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke, input string tag);
    logic [63:0] exp = ref_mul(a, b);
    int cycles = 0;
    @(negedge clk);
    mcand_i = a; mplier_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; mcand_i = ~a; mplier_i = b ^ 32'h5A5A_5A5A;
    check(busy_o == 1'b1, "R2 busy after start", {63'b0, busy_o}, 64'd1);
    while (!done_o && cycles < 100) begin
      if (busy_o) cycles++;
      if (poke && cycles == 10) begin
        start_i = 1'b1; mcand_i = 32'h1234_5678; mplier_i = 32'h9ABC_DEF0;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    check(cycles == W, {tag, " R3 busy length"}, 64'(cycles), 64'(W));
    check(done_o && !busy_o, {tag, " R3 done after busy"}, {62'b0, done_o, busy_o}, 64'd2);
    check({hi_o, lo_o} == exp, {tag, " R4 product"}, {hi_o, lo_o}, exp);
    @(negedge clk);
    check(!done_o, {tag, " R8 done one cycle"}, {63'b0, done_o}, 64'd0);
    check({hi_o, lo_o} == exp, {tag, " R7 product holds"}, {hi_o, lo_o}, exp);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] keep;
    void'($urandom(32'd20250611));
    rst_n = 1'b0; start_i = 1'b0; mcand_i = '0; mplier_i = '0;
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && hi_o == '0 && lo_o == '0, "R1 reset state",
          {hi_o, lo_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o && hi_o == '0 && lo_o == '0, "R1 after release",
          {62'b0, busy_o, done_o}, 64'd0);

    do_mul(32'd6, 32'd7, 1'b0, "basic");
    do_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R5 all-ones");
    check({hi_o, lo_o} == 64'hFFFF_FFFE_0000_0001, "R5 carry kept", {hi_o, lo_o},
          64'hFFFF_FFFE_0000_0001);
    do_mul(32'h0, 32'hDEAD_BEEF, 1'b0, "R9 zero mcand");
    do_mul(32'hCAFE_F00D, 32'h0, 1'b0, "R9 zero mplier");
    do_mul(32'h8000_0000, 32'h8000_0000, 1'b0, "msb");
    do_mul(32'h8765_4321, 32'h0BAD_F00D, 1'b1, "R6 ignored start");

    // R7: idle with moving operand inputs and no start
    keep = {hi_o, lo_o};
    for (int i = 0; i < 5; i++) begin
      mcand_i = $urandom; mplier_i = $urandom;
      @(negedge clk);
      check({hi_o, lo_o} == keep && !busy_o, "R7 idle hold", {hi_o, lo_o}, keep);
    end

    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      a = $urandom; b = $urandom;
      if (i % 8 == 3) a = 32'hFFFF_FFFF;
      do_mul(a, b, (i % 5 == 0), "R4 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule